// File: doc/BRIEF.md
# USB Endpoint Configuration and Status Register Bank

This block holds one byte-wide configuration and status register for each endpoint of a USB device controller. The CPU sees all of them through a single byte window, and a small endpoint-selection register picks which endpoint the window reads and writes. Software owns the enable, the NAK interrupt enable, the direction and the transfer type of each endpoint. The controller core reports events as single-cycle pulses, and each pulse carries its own endpoint index. These events set the NAK status flags and track the data toggle of the last data packet received.

In each byte, the two NAK flags are set by hardware and cleared by software. Writing 0 to a flag clears it, and writing 1 leaves it alone. The toggle bit is read-only. The bank ORs the enabled NAK flags of every endpoint into one interrupt request. It also gives the core each endpoint's enable and type, plus an effective direction that is forced to OUT for control endpoints.

Top module: `ep_csr_bank`

## Requirements
- R1: After a synchronous reset, every endpoint register reads 8'h80 (enabled, all other fields zero), the selection register reads 0 and `irq` is 0.
- R2: `win_rdata` shows the register of the currently selected endpoint in the same cycle. Its bit layout is: [7] enable, [6] NAK interrupt enable, [5] NAK-on-OUT flag, [4] NAK-on-IN flag, [3] toggle, [2] direction (1 = IN), [1:0] type.
- R3: A window write updates the enable, interrupt enable, direction and type fields of the selected endpoint only. A write to the selection register takes effect at the next clock edge.
- R4: The type codes are 00 control, 01 isochronous, 10 bulk and 11 interrupt, and they appear on `ep_kind`. `ep_dir_in` equals the stored direction bit, except that it is 0 when the type is control.
- R5: A NAK-on-OUT or NAK-on-IN event sets the matching flag of the endpoint named by the event's own index, whatever the window selection is.
- R6: A window write with 0 in a flag position clears that flag. A write with 1 in that position leaves the flag unchanged.
- R7: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: A PID event sets the toggle bit for DATA1 and clears it for DATA0. A window write to bit 3 has no effect on it.
- R9: `irq` is 1 exactly when some endpoint has its NAK interrupt enable set together with either NAK flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Write strobe for the endpoint-selection register |
| sel_wdata | input | 3 | New endpoint selection |
| sel_rdata | output | 3 | Current endpoint selection |
| win_we | input | 1 | Write strobe for the register window |
| win_wdata | input | 8 | Window write data |
| win_rdata | output | 8 | Register of the selected endpoint |
| nak_out_evt | input | 1 | Pulse: NAK sent in reply to a host OUT |
| nak_out_ep | input | 3 | Endpoint index of `nak_out_evt` |
| nak_in_evt | input | 1 | Pulse: NAK sent in reply to a host IN |
| nak_in_ep | input | 3 | Endpoint index of `nak_in_evt` |
| pid_evt | input | 1 | Pulse: data packet received |
| pid_ep | input | 3 | Endpoint index of `pid_evt` |
| pid_data1 | input | 1 | 1 for DATA1, 0 for DATA0 |
| ep_en | output | 8 | Per-endpoint enable |
| ep_kind | output | 16 | Per-endpoint type, two bits each, endpoint 0 lowest |
| ep_dir_in | output | 8 | Per-endpoint effective direction (1 = IN) |
| irq | output | 1 | Combined NAK interrupt request |

## Verification
The bench targets a NAK event for one endpoint that arrives while the window points at another endpoint. A design that decodes the event through the window selection would flag the wrong endpoint. It drives a software clear in the same cycle as a hardware set, which a design that gives software priority would lose. It writes ones into the flag and toggle positions, which a naive write would use to set the flags or corrupt the toggle. It also checks that a flag raised on an endpoint whose interrupt enable is 0 leaves `irq` low, and that a control endpoint with its direction bit set still reports OUT.

// File: rtl/ep_csr_pkg.sv
package ep_csr_pkg;

    typedef enum logic [1:0] {
        KIND_CTRL = 2'b00,
        KIND_ISO  = 2'b01,
        KIND_BULK = 2'b10,
        KIND_INTR = 2'b11
    } ep_kind_e;

    typedef struct packed {
        logic     en;
        logic     nak_ie;
        logic     nak_out;
        logic     nak_in;
        logic     tgl;
        logic     dir_in;
        ep_kind_e kind;
    } ep_reg_t;

    localparam ep_reg_t EP_RESET = '{en: 1'b1, nak_ie: 1'b0, nak_out: 1'b0,
                                     nak_in: 1'b0, tgl: 1'b0, dir_in: 1'b0,
                                     kind: KIND_CTRL};

    function automatic logic eff_dir_in(input ep_reg_t r);
        return r.dir_in && (r.kind != KIND_CTRL);
    endfunction

    function automatic logic wants_irq(input ep_reg_t r);
        return r.nak_ie && (r.nak_out || r.nak_in);
    endfunction

endpackage

// File: rtl/ep_sel_reg.sv
module ep_sel_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end

    assert_sel_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
    assert_sel_load_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> q == $past(wdata));
endmodule

// File: rtl/ep_slot.sv
module ep_slot
    import ep_csr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  ep_reg_t wdata,
    input  logic    set_out,
    input  logic    set_in,
    input  logic    pid_vld,
    input  logic    pid_d1,
    output ep_reg_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= EP_RESET;
        end else begin
            if (wr) begin
                q.en     <= wdata.en;
                q.nak_ie <= wdata.nak_ie;
                q.dir_in <= wdata.dir_in;
                q.kind   <= wdata.kind;
            end
            if (set_out)                 q.nak_out <= 1'b1;
            else if (wr && !wdata.nak_out) q.nak_out <= 1'b0;
            if (set_in)                  q.nak_in <= 1'b1;
            else if (wr && !wdata.nak_in)  q.nak_in <= 1'b0;
            if (pid_vld)                 q.tgl <= pid_d1;
        end
    end

    assert_out_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        set_out |=> q.nak_out);
    assert_in_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        set_in |=> q.nak_in);
    assert_out_rise_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(q.nak_out) |-> $past(set_out));
    assert_out_clear_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(q.nak_out) |-> ($past(wr) && !$past(wdata.nak_out)));
    assert_in_clear_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(q.nak_in) |-> ($past(wr) && !$past(wdata.nak_in)));
    assert_tgl_follow_R8: assert property (@(posedge clk) disable iff (rst)
        pid_vld |=> q.tgl == $past(pid_d1));
    assert_tgl_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !pid_vld |=> $stable(q.tgl));
endmodule

// File: rtl/ep_irq_merge.sv
module ep_irq_merge
    import ep_csr_pkg::*;
#(
    parameter int N = 8
) (
    input  ep_reg_t regs [N],
    output logic    irq
);
    logic [N-1:0] req;

    for (genvar i = 0; i < N; i++) begin : g_req
        assign req[i] = wants_irq(regs[i]);
    end

    assign irq = |req;
endmodule

// File: rtl/ep_csr_bank.sv
module ep_csr_bank
    import ep_csr_pkg::*;
#(
    parameter int NUM_EP = 8,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic [EPW-1:0]    sel_wdata,
    output logic [EPW-1:0]    sel_rdata,
    input  logic              win_we,
    input  logic [7:0]        win_wdata,
    output logic [7:0]        win_rdata,
    input  logic              nak_out_evt,
    input  logic [EPW-1:0]    nak_out_ep,
    input  logic              nak_in_evt,
    input  logic [EPW-1:0]    nak_in_ep,
    input  logic              pid_evt,
    input  logic [EPW-1:0]    pid_ep,
    input  logic              pid_data1,
    output logic [NUM_EP-1:0] ep_en,
    output logic [2*NUM_EP-1:0] ep_kind,
    output logic [NUM_EP-1:0] ep_dir_in,
    output logic              irq
);
    logic [EPW-1:0] sel;
    ep_reg_t        regs [NUM_EP];
    ep_reg_t        wr_word;

    assign wr_word = ep_reg_t'(win_wdata);

    ep_sel_reg #(.W(EPW)) u_sel (
        .clk(clk), .rst(rst), .we(sel_we), .wdata(sel_wdata), .q(sel)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        ep_slot u_slot (
            .clk    (clk),
            .rst    (rst),
            .wr     (win_we && (sel == EPW'(i))),
            .wdata  (wr_word),
            .set_out(nak_out_evt && (nak_out_ep == EPW'(i))),
            .set_in (nak_in_evt && (nak_in_ep == EPW'(i))),
            .pid_vld(pid_evt && (pid_ep == EPW'(i))),
            .pid_d1 (pid_data1),
            .q      (regs[i])
        );
        assign ep_en[i]         = regs[i].en;
        assign ep_kind[2*i +: 2] = regs[i].kind;
        assign ep_dir_in[i]     = eff_dir_in(regs[i]);
    end

    ep_irq_merge #(.N(NUM_EP)) u_irq (.regs(regs), .irq(irq));

    always_comb begin
        win_rdata = 8'h00;
        for (int i = 0; i < NUM_EP; i++)
            if (sel == EPW'(i)) win_rdata = regs[i];
    end
    assign sel_rdata = sel;

    assert_reset_view_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (win_rdata == 8'h80 && sel_rdata == '0 && !irq));
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(nak_out_evt || nak_in_evt || win_we));
    assert_ctrl_dir_R4: assert property (@(posedge clk) disable iff (rst)
        (win_rdata[1:0] == 2'b00) |-> !ep_dir_in[sel]);
endmodule

// File: tb/sim_ep_csr_bank.sv
module sim_ep_csr_bank;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_we = 0, win_we = 0, nak_out_evt = 0, nak_in_evt = 0, pid_evt = 0, pid_data1 = 0;
    logic [2:0] sel_wdata = 0, nak_out_ep = 0, nak_in_ep = 0, pid_ep = 0, sel_rdata;
    logic [7:0] win_wdata = 0, win_rdata, ep_en, ep_dir_in;
    logic [15:0] ep_kind;
    logic irq;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    ep_csr_bank u0 (.*);

    // {endpoint, written byte, expected readback}
    localparam logic [18:0] VEC [8] = '{
        {3'd0, 8'h80, 8'h80}, {3'd1, 8'hFD, 8'hC5}, {3'd2, 8'h06, 8'h06},
        {3'd3, 8'h47, 8'h47}, {3'd4, 8'h3B, 8'h03}, {3'd5, 8'hC4, 8'hC4},
        {3'd6, 8'h8E, 8'h86}, {3'd7, 8'h01, 8'h01}};

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic pick(input logic [2:0] ep);
        sel_we = 1; sel_wdata = ep; tick(); sel_we = 0;
    endtask

    task automatic put(input logic [7:0] d);
        win_we = 1; win_wdata = d; tick(); win_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        // R1: reset state of every endpoint
        chk("R1 sel", 16'(sel_rdata), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);
        for (int i = 0; i < 8; i++) begin
            pick(3'(i));
            chk("R1 reset byte", 16'(win_rdata), 16'h80);
        end
        // R2/R3/R4: table of writes, then readback
        for (int i = 0; i < 8; i++) begin
            pick(VEC[i][18:16]);
            put(VEC[i][15:8]);
        end
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            e = VEC[i][7:0];
            pick(VEC[i][18:16]);
            chk("R2 R3 readback", 16'(win_rdata), 16'(e));
            chk("R4 kind", 16'(ep_kind[2*i +: 2]), 16'(e[1:0]));
            chk("R4 dir", 16'(ep_dir_in[i]), 16'(e[2] && e[1:0] != 2'b00));
            chk("R3 enable", 16'(ep_en[i]), 16'(e[7]));
        end
        chk("R9 idle irq", 16'(irq), 16'h0);
        // R5: event on ep3 while window shows ep0
        pick(3'd0);
        nak_out_evt = 1; nak_out_ep = 3'd3; tick(); nak_out_evt = 0;
        chk("R5 other ep untouched", 16'(win_rdata), 16'h80);
        chk("R9 irq on enabled flag", 16'(irq), 16'h1);
        pick(3'd3);
        chk("R5 flag set by index", 16'(win_rdata), 16'h67);
        // R6: writing 1 keeps, writing 0 clears; nak_in bit 1 does not set
        put(8'h77);
        chk("R6 write one keeps", 16'(win_rdata), 16'h67);
        put(8'h47);
        chk("R6 write zero clears", 16'(win_rdata), 16'h47);
        chk("R9 irq drops", 16'(irq), 16'h0);
        // R7: hardware set beats simultaneous software clear
        nak_in_evt = 1; nak_in_ep = 3'd3; win_we = 1; win_wdata = 8'h47;
        tick(); nak_in_evt = 0; win_we = 0;
        chk("R7 set wins", 16'(win_rdata), 16'h57);
        chk("R9 irq on nak in", 16'(irq), 16'h1);
        put(8'h47);
        chk("R6 clear nak in", 16'(win_rdata), 16'h47);
        // R9: flag on an endpoint with interrupt disabled
        nak_in_evt = 1; nak_in_ep = 3'd2; tick(); nak_in_evt = 0;
        chk("R9 masked flag", 16'(irq), 16'h0);
        pick(3'd2);
        chk("R5 nak in on ep2", 16'(win_rdata), 16'h16);
        // R8: toggle tracking and write protection
        pid_evt = 1; pid_ep = 3'd6; pid_data1 = 1; tick(); pid_evt = 0;
        pick(3'd6);
        chk("R8 data1 sets", 16'(win_rdata), 16'h8E);
        put(8'h80);
        chk("R8 write ignores toggle", 16'(win_rdata), 16'h88);
        pid_evt = 1; pid_data1 = 0; tick(); pid_evt = 0;
        chk("R8 data0 clears", 16'(win_rdata), 16'h80);
        put(8'h88);
        chk("R8 write one ignored", 16'(win_rdata), 16'h80);
        // R1: reset again restores defaults
        rst = 1; tick(); rst = 0;
        chk("R1 re-reset byte", 16'(win_rdata), 16'h80);
        chk("R1 re-reset sel", 16'(sel_rdata), 16'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule